// File: doc/BRIEF.md
# Hop-Selectable Quadrature ROM Synthesizer

This block is a direct digital synthesizer. On every clock it emits one pair of 4-bit DAC codes, an in-phase and a quadrature sample of a low-frequency sinusoid. An analog single-sideband stage later combines the pair with a fixed 4.224 GHz carrier. The clock runs at the carrier rate, so the offsets of +264 MHz, -264 MHz and -792 MHz move the carrier to 4.488 GHz, 3.960 GHz and 3.432 GHz.

A 4-bit phase index walks a 16-entry cosine table in steps of 1 (264 MHz) or 3 (792 MHz). The sine is read from the same table a quarter turn behind. A negative offset inverts the quadrature code. A 2-bit hop command, qualified by a strobe, picks the band. The new setting applies one sample after the strobe. The phase index keeps running through every hop, so a hop takes two clocks. That is far inside the roughly 38-clock hop budget.

Top module: `quad_hop_dds`

## Requirements
- R1: The reset is synchronous and active low. While it is held, both outputs read 8, the phase index is 0 and the -792 MHz setting is selected. The first pair after release is therefore dacI=15 and dacQ=7.
- R2: The table entry for index k is floor(8 + 7.5*cos(2*pi*k/16)). Over k = 0..15 this gives 15,14,13,10,8,5,2,1,0,1,2,5,8,10,13,14. At each clock, dacI takes the entry at the current phase index.
- R3: At every clock the phase index advances by 3 (modulo 16) under command 00, and by 1 under commands 01 and 10.
- R4: The sine entry sits at index (phase-4) mod 16. Under command 10 (+264 MHz), dacQ is that entry. Under commands 00 (-792 MHz) and 01 (-264 MHz), dacQ is 15 minus that entry.
- R5: A command is sampled at a clock edge where hopStrobe is high. The pair formed at that same edge, and the phase step taken there, still use the old setting. The new setting governs the next edge onward.
- R6: Command 11 with the strobe high leaves the current setting unchanged.
- R7: A change of hopCmd while hopStrobe is low has no effect.
- R8: A hop never resets the phase index. The first pair after a hop continues from the index that the old step reached.
- R9: A new pair appears on every clock. Under command 00, dacI differs from its previous value at every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock at the carrier rate |
| rstN | input | 1 | Synchronous active-low reset |
| hopStrobe | input | 1 | Qualifies hopCmd for one clock |
| hopCmd | input | 2 | Band select: 00 = -792 MHz, 01 = -264 MHz, 10 = +264 MHz, 11 = hold |
| dacI | output | 4 | In-phase DAC code, offset binary |
| dacQ | output | 4 | Quadrature DAC code, offset binary |

## Verification
The bench targets the edge where a strobe lands. A design that applied the command one edge early would show the new step or Q sign a sample too soon, and one that applied it late would lag a sample. Hops are issued at nonzero phase and back to back, so a design that zeroed the accumulator on a hop would jump back to code 15. The reserved command and a command that changes without a strobe are both followed by runs of samples; either one, if wrongly taken, would alter the step or flip the sign of Q. The two negative bands are each compared with the positive band to catch a missing or misplaced Q inversion.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int PHASE_W = 4;
  localparam int DAC_W = 4;
  localparam int TABLE_LEN = 1 << PHASE_W;
  localparam int QUARTER = TABLE_LEN / 4;
  localparam logic [PHASE_W-1:0] STEP_FINE = PHASE_W'(1);
  localparam logic [PHASE_W-1:0] STEP_COARSE = PHASE_W'(3);
  localparam logic [DAC_W-1:0] CODE_MID = DAC_W'(1 << (DAC_W - 1));

  typedef enum logic [1:0] {
    HOP_LOW_BAND  = 2'b00,
    HOP_MID_BAND  = 2'b01,
    HOP_HIGH_BAND = 2'b10,
    HOP_HOLD      = 2'b11
  } hopCmd_e;

  typedef struct packed {
    logic [PHASE_W-1:0] phaseStep;
    logic               negateQ;
  } ctrlBus_t;
endpackage

// File: rtl/dds_hop_ctrl.sv
module dds_hop_ctrl
  import dds_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hopStrobe,
  input  logic [1:0] hopCmd,
  output ctrlBus_t   ctrlBus
);
  ctrlBus_t cur;
  ctrlBus_t nxt;
  hopCmd_e  cmd;

  assign cmd = hopCmd_e'(hopCmd);

  always_comb begin
    nxt = cur;
    if (hopStrobe) begin
      unique case (cmd)
        HOP_LOW_BAND:  nxt = '{phaseStep: STEP_COARSE, negateQ: 1'b1};
        HOP_MID_BAND:  nxt = '{phaseStep: STEP_FINE,   negateQ: 1'b1};
        HOP_HIGH_BAND: nxt = '{phaseStep: STEP_FINE,   negateQ: 1'b0};
        default:       nxt = cur;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cur <= '{phaseStep: STEP_COARSE, negateQ: 1'b1};
    else       cur <= nxt;
  end

  assign ctrlBus = cur;

  // R6
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hopStrobe && hopCmd == 2'b11) |=> $stable(cur));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hopStrobe |=> $stable(cur));

  // R5
  hop_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hopStrobe && hopCmd == 2'b10) |=> (cur.phaseStep == STEP_FINE && !cur.negateQ));

  // R3
  step_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cur.phaseStep == STEP_FINE || cur.phaseStep == STEP_COARSE));
endmodule

// File: rtl/dds_cos_rom.sv
module dds_cos_rom
  import dds_pkg::*;
(
  input  logic [PHASE_W-1:0] addr,
  output logic [DAC_W-1:0]   code
);
  always_comb begin
    unique case (addr)
      4'd0:    code = 4'd15;
      4'd1:    code = 4'd14;
      4'd2:    code = 4'd13;
      4'd3:    code = 4'd10;
      4'd4:    code = 4'd8;
      4'd5:    code = 4'd5;
      4'd6:    code = 4'd2;
      4'd7:    code = 4'd1;
      4'd8:    code = 4'd0;
      4'd9:    code = 4'd1;
      4'd10:   code = 4'd2;
      4'd11:   code = 4'd5;
      4'd12:   code = 4'd8;
      4'd13:   code = 4'd10;
      4'd14:   code = 4'd13;
      default: code = 4'd14;
    endcase
  end
endmodule

// File: rtl/dds_phase_path.sv
module dds_phase_path
  import dds_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlBus_t         ctrlBus,
  output logic [DAC_W-1:0] dacI,
  output logic [DAC_W-1:0] dacQ
);
  localparam int NUM_PORTS = 2;

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] romAddr [NUM_PORTS];
  logic [DAC_W-1:0]   romCode [NUM_PORTS];

  assign romAddr[0] = phase;
  assign romAddr[1] = phase - PHASE_W'(QUARTER);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rom
    dds_cos_rom rom_i (
      .addr(romAddr[g]),
      .code(romCode[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
      dacI  <= CODE_MID;
      dacQ  <= CODE_MID;
    end else begin
      phase <= phase + ctrlBus.phaseStep;
      dacI  <= romCode[0];
      dacQ  <= ctrlBus.negateQ ? ~romCode[1] : romCode[1];
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (phase == '0 && dacI == CODE_MID && dacQ == CODE_MID));

  // R3
  phase_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (phase != $past(phase)));
endmodule

// File: rtl/quad_hop_dds.sv
module quad_hop_dds
  import dds_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hopStrobe,
  input  logic [1:0]       hopCmd,
  output logic [DAC_W-1:0] dacI,
  output logic [DAC_W-1:0] dacQ
);
  ctrlBus_t ctrlBus;

  dds_hop_ctrl ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .hopStrobe(hopStrobe),
    .hopCmd(hopCmd),
    .ctrlBus(ctrlBus)
  );

  dds_phase_path path_i (
    .clk(clk),
    .rstN(rstN),
    .ctrlBus(ctrlBus),
    .dacI(dacI),
    .dacQ(dacQ)
  );
endmodule

// File: tb/quad_hop_dds_tb_top.sv
module quad_hop_dds_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hopStrobe = 1'b0;
  logic [1:0] hopCmd = 2'b00;
  logic [3:0] dacI;
  logic [3:0] dacQ;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int mPhase = 0;
  int mStep = 3;
  bit mNeg = 1;
  int expI = 0;
  int expQ = 0;

  always #5 clk = ~clk;

  quad_hop_dds dut_i (
    .clk(clk), .rstN(rstN), .hopStrobe(hopStrobe), .hopCmd(hopCmd),
    .dacI(dacI), .dacQ(dacQ)
  );

  function automatic int cosCode(int k);
    real x;
    x = 8.0 + 7.5 * $cos(2.0 * 3.14159265358979 * real'(k % 16) / 16.0) + 1.0e-9;
    return $rtoi(x);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: drive inputs, advance the model at the edge, compare at the negedge.
  task automatic tick(input logic [1:0] cmd, input bit stb, input string req);
    int s;
    hopCmd = cmd;
    hopStrobe = stb;
    @(posedge clk);
    expI = cosCode(mPhase);
    s = cosCode((mPhase + 12) % 16);
    expQ = mNeg ? 15 - s : s;
    mPhase = (mPhase + mStep) % 16;
    if (stb) begin
      case (cmd)
        2'b00: begin mStep = 3; mNeg = 1; end
        2'b01: begin mStep = 1; mNeg = 1; end
        2'b10: begin mStep = 1; mNeg = 0; end
        default: ;
      endcase
    end
    @(negedge clk);
    hopStrobe = 1'b0;
    check(req, "dacI", int'(dacI), expI);
    check(req, "dacQ", int'(dacQ), expQ);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "dacI in reset", int'(dacI), 8);
    check("R1", "dacQ in reset", int'(dacQ), 8);
    rstN = 1'b1;
    mPhase = 0; mStep = 3; mNeg = 1;
    tick(2'b00, 0, "R1");
    check("R1", "first dacI", int'(dacI), 15);
    check("R1", "first dacQ", int'(dacQ), 7);
  endtask

  task automatic testLowBand();
    int prev;
    prev = int'(dacI);
    for (int i = 0; i < 20; i++) begin
      tick(2'b00, 0, "R3");
      checks++;
      if (int'(dacI) == prev) begin
        fails++;
        $display("FAIL R9 dacI repeated: actual %0d expected not %0d", dacI, prev);
      end
      prev = int'(dacI);
    end
  endtask

  task automatic testHighBand();
    tick(2'b10, 1, "R5");
    tick(2'b10, 0, "R5");
    for (int i = 0; i < 20; i++) tick(2'b10, 0, "R4");
  endtask

  task automatic testMidBand();
    tick(2'b01, 1, "R5");
    for (int i = 0; i < 20; i++) tick(2'b01, 0, "R4");
  endtask

  task automatic testReserved();
    tick(2'b11, 1, "R6");
    for (int i = 0; i < 8; i++) tick(2'b11, 0, "R6");
  endtask

  task automatic testNoStrobe();
    for (int i = 0; i < 4; i++) tick(2'b00, 0, "R7");
    for (int i = 0; i < 4; i++) tick(2'b10, 0, "R7");
  endtask

  task automatic testContinuity();
    tick(2'b00, 1, "R8");
    for (int i = 0; i < 3; i++) tick(2'b00, 0, "R8");
    tick(2'b10, 1, "R8");
    for (int i = 0; i < 3; i++) tick(2'b10, 0, "R8");
    tick(2'b00, 1, "R5");
    tick(2'b01, 1, "R5");
    tick(2'b10, 1, "R5");
    tick(2'b00, 1, "R5");
    for (int i = 0; i < 6; i++) tick(2'b00, 0, "R2");
  endtask

  initial begin
    testReset();
    testLowBand();
    testHighBand();
    testMidBand();
    testReserved();
    testNoStrobe();
    testContinuity();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule